// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block is the register face of a 64-bit block cipher accelerator. A processor reaches it over a simple 32-bit bus with separate read and write strobes and a byte address. Behind it sits a cipher engine with a start/done handshake. The front-end holds the key words, the two IV words, the mode bits, a byte-count register, a revision word, a DMA control word and the interrupt enable and status bits. The cipher itself is not part of the block.

Software moves data one 64-bit block at a time. While the input window is open, it writes the two input words. One cycle after the second word lands, the front-end pulses the engine start. When the engine reports done, the result is latched and an output-ready event is raised. Software then reads both words back from the same two data addresses. That read retires the block and lowers the remaining byte count by eight. The input window reopens only while bytes remain, so the length register decides when the stream is finished. Input and output events alternate in the status register. Software clears them by writing zeros, and each one can raise the interrupt line through its own enable bit.

Top module: `blkc_front`

## Requirements
- R1: After reset, control, status, enable, length and mask all read 0, `irq` is 0 and `eng_start` is 0.
- R2: Key word k (0..5) is written and read at byte address 0x14 - ((k XOR 1) * 4): words 0/1 at 0x10/0x14, 2/3 at 0x08/0x0C, 4/5 at 0x00/0x04. Word k drives `eng_key[32k+31:32k]`.
- R3: The IV words at 0x18 and 0x1C drive `eng_iv` low and high halves. Control (0x20) bits 4, 3 and 2 (chaining, triple key, encrypt) are stored and drive `eng_mode[2:0]` as {bit4, bit3, bit2}. Writes to control bits 1:0 have no effect.
- R4: Control bit 1 (input window) reads 1 exactly when the remaining count is nonzero and no block is in flight. Status bit 1 is set within two cycles of the window opening.
- R5: `eng_start` is a one-cycle pulse in the cycle after the second of the two data words (0x28 low, 0x2C high) is written. `eng_din` = {word at 0x2C, word at 0x28}. One data word alone starts nothing.
- R6: On `eng_done`, the result is latched, control bit 0 reads 1 and status bit 2 is set. Reads of 0x28 and 0x2C return `eng_dout` low and high.
- R7: After both result words are read, control bit 0 clears and the length register (0x24) drops by 8, saturating at 0. The window reopens only if the count is still nonzero.
- R8: A write to status (0x3C) clears each of bits 1 and 2 written as 0 and leaves each written as 1 unchanged. All other status bits read 0.
- R9: `irq` is 1 exactly when some bit i in {1,2} is set in both status and enable (0x40).
- R10: The DMA control register (0x34) stores bits 5 (input enable), 6 (output enable) and 7 (start). Its other bits read 0.
- R11: The revision register (0x30) reads REV_MAJOR in bits 10:8 and REV_MINOR in bits 5:0. Writes to it have no effect.
- R12: Unmapped addresses read 0. Data writes while the input window is closed are ignored and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (data reads retire result words) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | Engine start pulse |
| eng_mode | output | 3 | {chaining, triple key, encrypt} |
| eng_key | output | 192 | Key words, word k at bits 32k+31:32k |
| eng_iv | output | 64 | IV words |
| eng_din | output | 64 | Input block |
| eng_done | input | 1 | Engine result valid pulse |
| eng_dout | input | 64 | Engine result block |

## Verification
Register writes land at the clock edge that samples the strobe. Control, length and data reads therefore show the new value from the next cycle, and `irq` follows enable and status writes one cycle after the edge. `eng_start` rises one cycle after the second data write and lasts one cycle. The stubbed engine answers four cycles after that, and output-ready appears one cycle later still. Status bit 1 lags the window by one extra cycle. The bench drives every access on the falling edge, samples between edges, and waits several spare cycles before checking any delayed event.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_IV_LO  = 8'h18;
  localparam logic [ADDR_W-1:0] A_IV_HI  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h20;
  localparam logic [ADDR_W-1:0] A_LEN    = 8'h24;
  localparam logic [ADDR_W-1:0] A_DAT_LO = 8'h28;
  localparam logic [ADDR_W-1:0] A_DAT_HI = 8'h2C;
  localparam logic [ADDR_W-1:0] A_REV    = 8'h30;
  localparam logic [ADDR_W-1:0] A_DMA    = 8'h34;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h3C;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h40;

  typedef enum logic [1:0] {ST_IN, ST_RUN, ST_OUT} seq_st_t;

  // key words are stored pair-swapped, counting down from the top of the bank
  function automatic logic [ADDR_W-1:0] key_addr(input int k);
    return 8'h14 - ADDR_W'((k ^ 1) * 4);
  endfunction
endpackage

// File: rtl/blkc_keybank.sv
module blkc_keybank
  import blkc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NKW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [NKW*DW-1:0] key_flat,
  output logic [2*DW-1:0]   iv_flat,
  output logic              rd_hit,
  output logic [DW-1:0]     rd_val
);
  logic [DW-1:0] kw [NKW];
  logic [DW-1:0] iv_lo, iv_hi;

  for (genvar k = 0; k < NKW; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n)                         kw[k] <= '0;
      else if (wr && addr == key_addr(k)) kw[k] <= wdata;
    end
    assign key_flat[k*DW +: DW] = kw[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iv_lo <= '0;
      iv_hi <= '0;
    end else if (wr) begin
      if (addr == A_IV_LO) iv_lo <= wdata;
      if (addr == A_IV_HI) iv_hi <= wdata;
    end
  end
  assign iv_flat = {iv_hi, iv_lo};

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int k = 0; k < NKW; k++) begin
      if (addr == key_addr(k)) begin
        rd_hit = 1'b1;
        rd_val = kw[k];
      end
    end
    if (addr == A_IV_LO) begin rd_hit = 1'b1; rd_val = iv_lo; end
    if (addr == A_IV_HI) begin rd_hit = 1'b1; rd_val = iv_hi; end
  end
endmodule

// File: rtl/blkc_seq.sv
module blkc_seq
  import blkc_pkg::*;
#(
  parameter int DW        = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic [DW-1:0]    wdata,
  input  logic             eng_done,
  input  logic [2*DW-1:0]  eng_dout,
  output logic             in_open,
  output logic             out_ready,
  output logic             eng_start,
  output logic [2*DW-1:0]  din,
  output logic [2*DW-1:0]  dout_q,
  output logic [LEN_W-1:0] remain,
  output logic             in_rise,
  output logic             out_rise
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BLK_BYTES);

  function automatic logic [LEN_W-1:0] next_remain(input logic [LEN_W-1:0] r);
    return (r >= STEP) ? r - STEP : '0;
  endfunction

  seq_st_t st;
  logic have_lo, have_hi, got_lo, got_hi, open_q;
  logic pair_done, blk_done, result_in;

  assign in_open   = (st == ST_IN) && (remain != '0);
  assign out_ready = (st == ST_OUT);
  assign pair_done = in_open && ((wr_lo && have_hi) || (wr_hi && have_lo));
  assign blk_done  = out_ready && ((rd_lo && got_hi) || (rd_hi && got_lo));
  assign result_in = (st == ST_RUN) && eng_done;
  assign in_rise   = in_open && !open_q;
  assign out_rise  = result_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IN; have_lo <= 1'b0; have_hi <= 1'b0;
      got_lo <= 1'b0; got_hi <= 1'b0; open_q <= 1'b0;
      eng_start <= 1'b0; din <= '0; dout_q <= '0; remain <= '0;
    end else begin
      open_q    <= in_open;
      eng_start <= pair_done;
      if (in_open && wr_lo) begin din[DW-1:0]    <= wdata; have_lo <= 1'b1; end
      if (in_open && wr_hi) begin din[2*DW-1:DW] <= wdata; have_hi <= 1'b1; end
      if (pair_done) begin
        st <= ST_RUN; have_lo <= 1'b0; have_hi <= 1'b0;
      end
      if (result_in) begin
        st <= ST_OUT; dout_q <= eng_dout;
      end
      if (out_ready && rd_lo) got_lo <= 1'b1;
      if (out_ready && rd_hi) got_hi <= 1'b1;
      if (blk_done) begin
        st <= ST_IN; got_lo <= 1'b0; got_hi <= 1'b0;
      end
      if (len_wr)        remain <= len_val;
      else if (blk_done) remain <= next_remain(remain);
    end
  end

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r5_start_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (st == ST_RUN) && ($past(st) == ST_IN));
  a_r6_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    result_in |=> out_ready);
  a_r7_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !len_wr) |=> (remain == next_remain($past(remain))));
endmodule

// File: rtl/blkc_irq.sv
module blkc_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_in,
  input  logic       set_out,
  input  logic       wr_stat,
  input  logic       wr_en,
  input  logic [1:0] wbits,   // [0] = data-in bit, [1] = data-out bit
  output logic [1:0] stat,
  output logic [1:0] en,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      if (wr_en) en <= wbits;
      stat <= (wr_stat ? (stat & wbits) : stat) | {set_out, set_in};
    end
  end

  assign irq = |(stat & en);

  a_r8_clear_in: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wbits[0] && !set_in) |=> !stat[0]);
  a_r8_keep_out: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[1] && stat[1]) |=> stat[1]);
endmodule

// File: rtl/blkc_front.sv
module blkc_front
  import blkc_pkg::*;
#(
  parameter int         DW        = 32,
  parameter int         NKW       = 6,
  parameter int         LEN_W     = 16,
  parameter int         BLK_BYTES = 8,
  parameter logic [2:0] REV_MAJOR = 3'd2,
  parameter logic [5:0] REV_MINOR = 6'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [2:0]        eng_mode,
  output logic [NKW*DW-1:0] eng_key,
  output logic [2*DW-1:0]   eng_iv,
  output logic [2*DW-1:0]   eng_din,
  input  logic              eng_done,
  input  logic [2*DW-1:0]   eng_dout
);
  logic [2:0] mode_q, dma_q;
  logic       kb_hit;
  logic [DW-1:0] kb_val;
  logic in_open, out_ready, in_rise, out_rise;
  logic [2*DW-1:0] dout_q;
  logic [LEN_W-1:0] remain;
  logic [1:0] stat, en;

  wire wr_lo = bus_wr && bus_addr == A_DAT_LO;
  wire wr_hi = bus_wr && bus_addr == A_DAT_HI;
  wire rd_lo = bus_rd && bus_addr == A_DAT_LO;
  wire rd_hi = bus_rd && bus_addr == A_DAT_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      dma_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) mode_q <= bus_wdata[4:2];
      if (bus_addr == A_DMA)  dma_q  <= bus_wdata[7:5];
    end
  end
  assign eng_mode = mode_q;

  blkc_keybank #(.DW(DW), .NKW(NKW)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .key_flat(eng_key), .iv_flat(eng_iv), .rd_hit(kb_hit), .rd_val(kb_val));

  blkc_seq #(.DW(DW), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .len_wr(bus_wr && bus_addr == A_LEN), .len_val(bus_wdata[LEN_W-1:0]),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi), .wdata(bus_wdata),
    .eng_done(eng_done), .eng_dout(eng_dout),
    .in_open(in_open), .out_ready(out_ready), .eng_start(eng_start), .din(eng_din),
    .dout_q(dout_q), .remain(remain), .in_rise(in_rise), .out_rise(out_rise));

  blkc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_in(in_rise), .set_out(out_rise),
    .wr_stat(bus_wr && bus_addr == A_STAT), .wr_en(bus_wr && bus_addr == A_IEN),
    .wbits(bus_wdata[2:1]), .stat(stat), .en(en), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    if (kb_hit) bus_rdata = kb_val;
    else begin
      case (bus_addr)
        A_CTRL:   bus_rdata = DW'({mode_q, in_open, out_ready});
        A_LEN:    bus_rdata = DW'(remain);
        A_DAT_LO: bus_rdata = dout_q[DW-1:0];
        A_DAT_HI: bus_rdata = dout_q[2*DW-1:DW];
        A_REV:    bus_rdata = DW'({REV_MAJOR, 2'b00, REV_MINOR});
        A_DMA:    bus_rdata = DW'({dma_q, 5'b0});
        A_STAT:   bus_rdata = DW'({stat, 1'b0});
        A_IEN:    bus_rdata = DW'({en, 1'b0});
        default:  bus_rdata = '0;
      endcase
    end
  end

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !irq);
endmodule

// File: tb/sim_blkc_front.sv
`timescale 1ns/1ps
module sim_blkc_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, eng_start, eng_done;
  logic [2:0] eng_mode;
  logic [191:0] eng_key;
  logic [63:0] eng_iv, eng_din, eng_dout;

  int checks = 0, fails = 0, starts = 0;
  logic [31:0] kval [6];
  logic [2:0] stub_cnt;

  always #2 clk = ~clk;

  blkc_front u0 (.*);

  // stub engine: swaps the halves, mixes in key words 0/1 and mode, answers 4 cycles later
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_done <= 1'b0; stub_cnt <= '0; eng_dout <= '0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        starts   <= starts + 1;
        stub_cnt <= 3'd3;
        eng_dout <= {eng_din[31:0], eng_din[63:32]} ^ eng_key[63:0] ^ {61'b0, eng_mode};
      end else if (stub_cnt != 0) begin
        stub_cnt <= stub_cnt - 1;
        if (stub_cnt == 3'd1) eng_done <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h20, v); chk("R1 ctrl", v, 0);
    rd(8'h3C, v); chk("R1 status", v, 0);
    rd(8'h40, v); chk("R1 enable", v, 0);
    rd(8'h24, v); chk("R1 length", v, 0);
    rd(8'h34, v); chk("R1 dma", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0);
  endtask

  task automatic t_keys;
    logic [31:0] v;
    logic [7:0] kad [6] = '{8'h10, 8'h14, 8'h08, 8'h0C, 8'h00, 8'h04};
    for (int k = 0; k < 6; k++) begin
      kval[k] = 32'hA5C3_0000 + 32'(k * 32'h111);
      wr(kad[k], kval[k]);
    end
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R2 key%0d port", k), eng_key[k*32 +: 32], kval[k]);
      rd(kad[k], v); chk($sformatf("R2 key%0d read", k), v, kval[k]);
    end
    wr(8'h18, 32'h1111_2222); wr(8'h1C, 32'h3333_4444);
    chk("R3 iv port", eng_iv, 64'h3333_4444_1111_2222);
    wr(8'h20, 32'h0000_001F);
    rd(8'h20, v); chk("R3 ctrl bits1:0 ignored", v, 32'h1C);
    chk("R3 mode port", eng_mode, 3'b111);
    wr(8'h20, 32'h0000_0008);
    chk("R3 mode triple only", eng_mode, 3'b010);
  endtask

  task automatic run_block(input logic [31:0] lo, input logic [31:0] hi,
                           input logic [2:0] mode, input logic [31:0] left);
    logic [31:0] v;
    wr(8'h28, lo);
    chk("R5 no start after one word", eng_start, 0);
    wr(8'h2C, hi);
    chk("R5 start pulse", eng_start, 1);
    chk("R5 din", eng_din, {hi, lo});
    idle(1);
    chk("R5 start one cycle", eng_start, 0);
    idle(6);
    rd(8'h20, v); chk("R6 output ready", v[1:0], 2'b01);
    rd(8'h3C, v); chk("R6 status out", v[2], 1);
    rd(8'h28, v); chk("R6 result lo", v, hi ^ kval[0] ^ {29'b0, mode});
    rd(8'h20, v); chk("R7 ready held after one read", v[0], 1);
    rd(8'h2C, v); chk("R6 result hi", v, lo ^ kval[1]);
    rd(8'h24, v); chk("R7 length step", v, left);
    rd(8'h20, v); chk("R7 window after block", v[1:0], {(left != 0), 1'b0});
  endtask

  task automatic t_blocks;
    logic [31:0] v;
    wr(8'h20, 32'h0000_0014);             // chaining + encrypt
    wr(8'h24, 32'd16);
    idle(2);
    rd(8'h20, v); chk("R4 window open", v[1:0], 2'b10);
    rd(8'h3C, v); chk("R4 status in", v, 32'h2);
    wr(8'h3C, 32'h0);
    run_block(32'hDEAD_BEEF, 32'h0123_4567, 3'b101, 32'd8);
    run_block(32'hFFFF_0000, 32'h8000_0001, 3'b101, 32'd0);
    chk("R7 no extra starts", 64'(starts), 2);
    wr(8'h24, 32'd5);                      // short count saturates at 0
    run_block(32'h0000_0001, 32'h0000_0002, 3'b101, 32'd0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    rd(8'h3C, v); chk("R8 status both set", v, 32'h6);
    wr(8'h40, 32'h2);
    chk("R9 irq on in", irq, 1);
    wr(8'h3C, 32'h4);
    rd(8'h3C, v); chk("R8 clear in keep out", v, 32'h4);
    chk("R9 irq off", irq, 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R9 enable bits", v, 32'h6);
    chk("R9 irq on out", irq, 1);
    wr(8'h3C, 32'h0);
    rd(8'h3C, v); chk("R8 cleared", v, 0);
    chk("R9 irq cleared", irq, 0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk("R8 ones do not set", v, 0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R10 dma bits", v, 32'hE0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R11 revision", v, 32'h0000_0209);
    rd(8'h38, v); chk("R12 unmapped 38", v, 0);
    rd(8'h44, v); chk("R12 unmapped 44", v, 0);
    rd(8'h80, v); chk("R12 unmapped 80", v, 0);
    wr(8'h28, 32'h1234_5678); wr(8'h2C, 32'h9ABC_DEF0);
    idle(6);
    chk("R12 closed window no start", 64'(starts), 3);
    rd(8'h20, v); chk("R12 window closed", v[1:0], 2'b00);
    rd(8'h28, v); chk("R12 result kept", v, 32'h2 ^ kval[0] ^ 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_keys;
    t_blocks;
    t_irq;
    t_misc;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule